// File: doc/BRIEF.md
# Vector-Length-Scaled Prefetch Controller

This block sits between a data cache and DDR memory and decides which lines to fetch when the cache misses. On a miss notification it first fetches the missing line (the demand fetch). When that line has been written into the cache, it walks forward through the following lines and requests each one that the cache does not already hold. The requests go out one at a time, in ascending line order, and stop at the end of the memory page that holds the missed line.

How far ahead the block fetches depends on the kind of access. A scalar miss uses a fixed number of lines set by a parameter. A vector miss scales with the vector length of the access: the block covers a multiple of the vector length, chosen at run time between 1× and 8×, rounded up to whole lines.

A new demand miss always takes priority over prefetching. A prefetch that has not yet been handed to memory is dropped. A prefetch that memory has already accepted is allowed to return, but its line is not written into the cache. Residency is tested through a probe port that the cache answers in the same cycle.

Top module: `vl_prefetch_ctrl`

## Requirements
- R1: On a miss accepted while idle, the first memory request carries the missed line address with `mem_req_pf`=0. The cycle after `mem_ack`, exactly one `fill_valid` pulse appears with that address and `fill_pf`=0.
- R2: After the demand fill, a scalar miss (`miss_is_vec`=0) prefetches lines addr+1 up to addr+PF_LINES (default 3) in ascending order, each with `mem_req_pf`=1. Each prefetched line is filled with `fill_pf`=1 in the cycle after its `mem_ack`.
- R3: A vector miss prefetches ceil(k×VL / ELEMS_PER_LINE) lines, where k = `cfg_vmult`+1 and ELEMS_PER_LINE = 4 by default. The encoding 0 gives 1×VL and 7 gives 8×VL, and VL = 0 gives no prefetch.
- R4: Each prefetch candidate is shown on `probe_addr`. If `probe_hit` is 1, that line is skipped without a memory request.
- R5: No prefetch address lies outside the PAGE_LINES-aligned page (default 64 lines) of the missed line.
- R6: A miss that arrives while a prefetch request is waiting on `mem_busy` cancels the remaining prefetches. The next accepted request is the demand for the new miss.
- R7: A miss that arrives while an accepted prefetch awaits `mem_ack` causes that returning line to produce no fill. The new demand request follows.
- R8: A miss that arrives while a demand fetch is outstanding is ignored: no request for it is ever made.
- R9: A request held off by `mem_busy` keeps its address until it is accepted. A request is accepted in a cycle where `mem_req`=1 and `mem_busy`=0.
- R10: At most one request is outstanding: no `mem_req` is raised between acceptance and `mem_ack`.
- R11: While reset is asserted, `mem_req` and `fill_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss notification strobe |
| miss_addr | input | LINE_AW | Line address of the miss |
| miss_is_vec | input | 1 | 1 for a vector access |
| miss_vlen | input | VL_W | Vector length in elements |
| cfg_vmult | input | 3 | Vector multiplier minus one |
| mem_req | output | 1 | Memory request valid |
| mem_req_addr | output | LINE_AW | Requested line address |
| mem_req_pf | output | 1 | 1 when the request is a prefetch |
| mem_busy | input | 1 | Memory cannot accept a request this cycle |
| mem_ack | input | 1 | Line for the outstanding request has returned |
| probe_addr | output | LINE_AW | Candidate line for the residency probe |
| probe_hit | input | 1 | Candidate line is already in the cache |
| fill_valid | output | 1 | Write the returned line into the cache |
| fill_addr | output | LINE_AW | Line address of the fill |
| fill_pf | output | 1 | Fill comes from a prefetch |

## Verification
The bound checker checks four rules on every cycle:
- only one request is ever outstanding;
- a stalled demand request keeps its address;
- a fill appears only the cycle after a memory acknowledge;
- every prefetch address lies ahead of the latest demand line and inside its page.

Only the bench scenarios can show the rest:
- the exact prefetch count for scalar and vector misses, including multiplier encoding and rounding;
- skipping of resident lines;
- the discarded fill after a cancelled in-flight prefetch;
- the ignoring of a miss during a demand fetch.

In those scenarios, residency patterns and memory stalls are random.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DREQ,
      ST_DWAIT,
      ST_PREQ,
      ST_PWAIT,
      ST_DRAIN
   } pfc_state_e;
endpackage

// File: rtl/pfc_depth.sv
module pfc_depth #(
   parameter int LINE_AW        = 16,
   parameter int VL_W           = 5,
   parameter int CNT_W          = 6,
   parameter int PF_LINES       = 3,
   parameter int ELEMS_PER_LINE = 4,
   parameter int PAGE_LINES     = 64,
   parameter bit VEC_EN         = 1'b1
) (
   input  logic [LINE_AW-1:0] line_addr,
   input  logic               is_vec,
   input  logic [VL_W-1:0]    vlen,
   input  logic [2:0]         vmult,
   output logic [CNT_W-1:0]   count
);
   localparam int EPL_SH = $clog2(ELEMS_PER_LINE);
   localparam int PG_SH  = $clog2(PAGE_LINES);
   localparam int PW     = VL_W + 4;

   logic [PG_SH-1:0] room;
   int               raw_i;
   int               room_i;

   // lines left in the page after the missed one
   assign room = ~line_addr[PG_SH-1:0];

   generate
      if (VEC_EN) begin : g_vec
         logic [3:0]    mult_f;
         logic [PW-1:0] scaled;
         logic [PW-1:0] vec_lines;
         always_comb begin
            mult_f    = {1'b0, vmult} + 4'd1;
            scaled    = {{VL_W{1'b0}}, mult_f} * {4'd0, vlen};
            vec_lines = (scaled + PW'(ELEMS_PER_LINE - 1)) >> EPL_SH;
            raw_i     = is_vec ? int'(vec_lines) : PF_LINES;
         end
      end else begin : g_scalar_only
         logic unused_vec;
         assign unused_vec = ^{is_vec, vlen, vmult};
         always_comb raw_i = PF_LINES;
      end
   endgenerate

   always_comb begin
      room_i = int'(room);
      count  = (raw_i < room_i) ? CNT_W'(raw_i) : CNT_W'(room_i);
   end
endmodule

// File: rtl/pfc_seq.sv
module pfc_seq
   import pfc_pkg::*;
#(
   parameter int LINE_AW = 16,
   parameter int CNT_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               miss_valid,
   input  logic [LINE_AW-1:0] miss_addr,
   input  logic [CNT_W-1:0]   new_count,
   input  logic               mem_busy,
   input  logic               mem_ack,
   input  logic               probe_hit,
   output logic               mem_req,
   output logic [LINE_AW-1:0] mem_req_addr,
   output logic               mem_req_pf,
   output logic [LINE_AW-1:0] probe_addr,
   output logic               ret_valid,
   output logic [LINE_AW-1:0] ret_addr,
   output logic               ret_pf
);
   pfc_state_e         st, st_n;
   logic [LINE_AW-1:0] cur, cur_n;
   logic [LINE_AW-1:0] nxt, nxt_n;
   logic [CNT_W-1:0]   left, left_n;
   logic               load;

   always_comb begin
      st_n   = st;
      cur_n  = cur;
      nxt_n  = nxt;
      left_n = left;
      load   = 1'b0;
      unique case (st)
         ST_IDLE:  load = miss_valid;
         ST_DREQ:  if (!mem_busy) st_n = ST_DWAIT;
         ST_DWAIT: if (mem_ack) st_n = (left == '0) ? ST_IDLE : ST_PREQ;
         ST_PREQ: begin
            if (miss_valid) load = 1'b1;
            else if (left == '0) st_n = ST_IDLE;
            else if (probe_hit) begin
               nxt_n  = nxt + LINE_AW'(1);
               left_n = left - CNT_W'(1);
            end else if (!mem_busy) st_n = ST_PWAIT;
         end
         ST_PWAIT: begin
            if (mem_ack) begin
               nxt_n  = nxt + LINE_AW'(1);
               left_n = left - CNT_W'(1);
               if (miss_valid) load = 1'b1;
               else st_n = (left == CNT_W'(1)) ? ST_IDLE : ST_PREQ;
            end else if (miss_valid) begin
               load = 1'b1;
            end
         end
         ST_DRAIN: if (mem_ack) st_n = ST_DREQ;
         default:  st_n = ST_IDLE;
      endcase
      if (load) begin
         cur_n  = miss_addr;
         nxt_n  = miss_addr + LINE_AW'(1);
         left_n = new_count;
         st_n   = (st == ST_PWAIT && !mem_ack) ? ST_DRAIN : ST_DREQ;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cur  <= '0;
         nxt  <= '0;
         left <= '0;
      end else begin
         st   <= st_n;
         cur  <= cur_n;
         nxt  <= nxt_n;
         left <= left_n;
      end
   end

   assign probe_addr   = nxt;
   assign mem_req      = (st == ST_DREQ) ||
                         (st == ST_PREQ && left != '0 && !probe_hit && !miss_valid);
   assign mem_req_addr = (st == ST_DREQ) ? cur : nxt;
   assign mem_req_pf   = (st == ST_PREQ);
   assign ret_valid    = mem_ack && (st == ST_DWAIT || st == ST_PWAIT);
   assign ret_addr     = (st == ST_DWAIT) ? cur : nxt;
   assign ret_pf       = (st == ST_PWAIT);
endmodule

// File: rtl/pfc_fill.sv
module pfc_fill #(
   parameter int LINE_AW = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ret_valid,
   input  logic [LINE_AW-1:0] ret_addr,
   input  logic               ret_pf,
   output logic               fill_valid,
   output logic [LINE_AW-1:0] fill_addr,
   output logic               fill_pf
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_valid <= 1'b0;
         fill_addr  <= '0;
         fill_pf    <= 1'b0;
      end else begin
         fill_valid <= ret_valid;
         if (ret_valid) begin
            fill_addr <= ret_addr;
            fill_pf   <= ret_pf;
         end
      end
   end
endmodule

// File: rtl/vl_prefetch_ctrl.sv
module vl_prefetch_ctrl #(
   parameter int LINE_AW     = 16,
   parameter int LINE_BYTES  = 16,
   parameter int ELEM_BYTES  = 4,
   parameter int MVL         = 16,
   parameter int PF_LINES    = 3,
   parameter int PAGE_LINES  = 64,
   parameter int CACHE_LINES = 256,
   parameter bit VEC_EN      = 1'b1,
   localparam int VL_W       = $clog2(MVL + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               miss_valid,
   input  logic [LINE_AW-1:0] miss_addr,
   input  logic               miss_is_vec,
   input  logic [VL_W-1:0]    miss_vlen,
   input  logic [2:0]         cfg_vmult,
   output logic               mem_req,
   output logic [LINE_AW-1:0] mem_req_addr,
   output logic               mem_req_pf,
   input  logic               mem_busy,
   input  logic               mem_ack,
   output logic [LINE_AW-1:0] probe_addr,
   input  logic               probe_hit,
   output logic               fill_valid,
   output logic [LINE_AW-1:0] fill_addr,
   output logic               fill_pf
);
   localparam int EPL     = LINE_BYTES / ELEM_BYTES;
   localparam int MAX_VEC = (8 * MVL + EPL - 1) / EPL;
   localparam int MAX_CNT = (MAX_VEC > PF_LINES) ? MAX_VEC : PF_LINES;
   localparam int CNT_W   = $clog2(MAX_CNT + 1);

   generate
      if (PAGE_LINES < 2 || (PAGE_LINES & (PAGE_LINES - 1)) != 0) begin : g_bad_page
         $error("PAGE_LINES must be a power of two of at least 2");
      end
      if (LINE_BYTES % ELEM_BYTES != 0 || (EPL & (EPL - 1)) != 0) begin : g_bad_epl
         $error("elements per line must be a power of two");
      end
      if (PF_LINES < 0 || PF_LINES >= CACHE_LINES) begin : g_bad_pf
         $error("PF_LINES must be below the cache capacity");
      end
      if (MAX_VEC >= CACHE_LINES) begin : g_bad_vec
         $error("8x the maximum vector length must stay below the cache capacity");
      end
      if (LINE_AW <= $clog2(PAGE_LINES)) begin : g_bad_aw
         $error("LINE_AW must exceed the page offset width");
      end
   endgenerate

   logic [CNT_W-1:0]   new_count;
   logic               ret_valid;
   logic [LINE_AW-1:0] ret_addr;
   logic               ret_pf;

   pfc_depth #(
      .LINE_AW(LINE_AW), .VL_W(VL_W), .CNT_W(CNT_W), .PF_LINES(PF_LINES),
      .ELEMS_PER_LINE(EPL), .PAGE_LINES(PAGE_LINES), .VEC_EN(VEC_EN)
   ) u_depth (
      .line_addr(miss_addr), .is_vec(miss_is_vec), .vlen(miss_vlen),
      .vmult(cfg_vmult), .count(new_count)
   );

   pfc_seq #(.LINE_AW(LINE_AW), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
      .new_count(new_count), .mem_busy(mem_busy), .mem_ack(mem_ack),
      .probe_hit(probe_hit), .mem_req(mem_req), .mem_req_addr(mem_req_addr),
      .mem_req_pf(mem_req_pf), .probe_addr(probe_addr), .ret_valid(ret_valid),
      .ret_addr(ret_addr), .ret_pf(ret_pf)
   );

   pfc_fill #(.LINE_AW(LINE_AW)) u_fill (
      .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_addr(ret_addr),
      .ret_pf(ret_pf), .fill_valid(fill_valid), .fill_addr(fill_addr),
      .fill_pf(fill_pf)
   );
endmodule

// File: rtl/vl_prefetch_ctrl_chk.sv
module vl_prefetch_ctrl_chk #(
   parameter int LINE_AW    = 16,
   parameter int PAGE_LINES = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic               miss_valid,
   input logic               mem_req,
   input logic [LINE_AW-1:0] mem_req_addr,
   input logic               mem_req_pf,
   input logic               mem_busy,
   input logic               mem_ack,
   input logic               fill_valid
);
   localparam int PG_SH = $clog2(PAGE_LINES);

   logic               outst;
   logic [LINE_AW-1:0] dem_line;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outst    <= 1'b0;
         dem_line <= '0;
      end else begin
         if (mem_req && !mem_busy) outst <= 1'b1;
         else if (mem_ack) outst <= 1'b0;
         if (mem_req && !mem_busy && !mem_req_pf) dem_line <= mem_req_addr;
      end
   end

   // R10
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      outst |-> !mem_req);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_busy && !mem_req_pf && !miss_valid) |=>
         (mem_req && $stable(mem_req_addr)));

   // R1
   fill_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> $past(mem_ack));

   // R5
   pf_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_req_pf) |->
         (mem_req_addr[LINE_AW-1:PG_SH] == dem_line[LINE_AW-1:PG_SH] &&
          mem_req_addr > dem_line));
endmodule

bind vl_prefetch_ctrl vl_prefetch_ctrl_chk #(
   .LINE_AW(LINE_AW), .PAGE_LINES(PAGE_LINES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .mem_req(mem_req),
   .mem_req_addr(mem_req_addr), .mem_req_pf(mem_req_pf), .mem_busy(mem_busy),
   .mem_ack(mem_ack), .fill_valid(fill_valid)
);

// File: tb/vl_prefetch_ctrl_test.sv
module vl_prefetch_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic [15:0] miss_addr = '0;
   logic        miss_is_vec = 1'b0;
   logic [4:0]  miss_vlen = '0;
   logic [2:0]  cfg_vmult = '0;
   logic        mem_req;
   logic [15:0] mem_req_addr;
   logic        mem_req_pf;
   logic        mem_busy = 1'b0;
   logic        mem_ack = 1'b0;
   logic [15:0] probe_addr;
   logic        probe_hit;
   logic        fill_valid;
   logic [15:0] fill_addr;
   logic        fill_pf;

   always #4 clk = ~clk;

   bit res [0:4095];
   assign probe_hit = res[probe_addr[11:0]];

   vl_prefetch_ctrl uut (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
      .miss_is_vec(miss_is_vec), .miss_vlen(miss_vlen), .cfg_vmult(cfg_vmult),
      .mem_req(mem_req), .mem_req_addr(mem_req_addr), .mem_req_pf(mem_req_pf),
      .mem_busy(mem_busy), .mem_ack(mem_ack), .probe_addr(probe_addr),
      .probe_hit(probe_hit), .fill_valid(fill_valid), .fill_addr(fill_addr),
      .fill_pf(fill_pf)
   );

   int nchk = 0, nerr = 0;
   logic [15:0] eq_addr [0:63];
   bit          eq_pf   [0:63];
   int  head = 0, tail = 0;
   bit  inflight = 0, infl_pf = 0, infl_drop = 0;
   logic [15:0] infl_addr = '0;
   int  lat = 0, fixed_lat = 0;
   bit  fe_valid = 0, fe_pf = 0, fe_drop = 0;
   logic [15:0] fe_addr = '0;
   bit  force_busy = 0;
   bit  nm_valid = 0, nm_vec = 0;
   logic [15:0] nm_addr = '0;
   logic [4:0]  nm_vl = '0;
   string cur_tag = "R2";

   function automatic int exp_count(int addr, bit vec, int vl, int m);
      int room, raw;
      room = 63 - (addr % 64);
      raw  = vec ? (((m + 1) * vl) + 3) / 4 : 3;
      return (raw < room) ? raw : room;
   endfunction

   function automatic void build(int addr, bit vec, int vl, int m);
      int n;
      head = 0; tail = 0;
      eq_addr[0] = 16'(addr); eq_pf[0] = 0; tail = 1;
      n = exp_count(addr, vec, vl, m);
      for (int i = 1; i <= n; i++) begin
         if (!res[addr + i]) begin
            eq_addr[tail] = 16'(addr + i); eq_pf[tail] = 1; tail++;
         end
      end
   endfunction

   task automatic step();
      @(negedge clk);
      if (fe_valid) begin
         nchk++;
         if (fe_drop) begin
            if (fill_valid) begin
               nerr++;
               $display("FAIL R7: fill_valid=%0b addr %0h, expected 0", fill_valid, fill_addr);
            end
         end else begin
            if (!fill_valid || fill_addr != fe_addr || fill_pf != fe_pf) begin
               nerr++;
               $display("FAIL %s: fill v=%0b addr %0h pf %0b, expected 1 %0h %0b",
                        fe_pf ? "R2" : "R1", fill_valid, fill_addr, fill_pf, fe_addr, fe_pf);
            end
            res[fe_addr[11:0]] = 1;
         end
         fe_valid = 0;
      end else if (fill_valid) begin
         nchk++; nerr++;
         $display("FAIL R1: unexpected fill addr %0h, expected none", fill_addr);
      end
      mem_ack = 0;
      if (inflight) begin
         lat--;
         if (lat == 0) begin
            mem_ack = 1; fe_valid = 1; fe_addr = infl_addr; fe_pf = infl_pf;
            fe_drop = infl_drop; inflight = 0;
         end
      end
      miss_valid = nm_valid; miss_addr = nm_addr; miss_is_vec = nm_vec; miss_vlen = nm_vl;
      nm_valid = 0;
      mem_busy = force_busy ? 1'b1 : ($urandom % 10 < 3);
      #1;
      if (mem_req && !mem_busy) begin
         nchk++;
         if (inflight) begin
            nerr++;
            $display("FAIL R10: request %0h while %0h outstanding, expected none", mem_req_addr, infl_addr);
         end
         if (head >= tail) begin
            nerr++;
            $display("FAIL %s: extra request %0h pf %0b, expected none", cur_tag, mem_req_addr, mem_req_pf);
         end else begin
            if (mem_req_addr != eq_addr[head] || mem_req_pf != eq_pf[head]) begin
               nerr++;
               $display("FAIL %s: request %0h pf %0b, expected %0h pf %0b",
                        (head == 0) ? "R1" : cur_tag, mem_req_addr, mem_req_pf, eq_addr[head], eq_pf[head]);
            end
            head++;
         end
         inflight = 1; infl_addr = mem_req_addr; infl_pf = mem_req_pf; infl_drop = 0;
         lat = (fixed_lat != 0) ? fixed_lat : 1 + int'($urandom % 4);
      end
   endtask

   task automatic issue(int addr, bit vec, int vl, int m, bit accept, bit drop);
      nm_valid = 1; nm_addr = 16'(addr); nm_vec = vec; nm_vl = 5'(vl);
      cfg_vmult = 3'(m);
      if (accept) build(addr, vec, vl, m);
      if (drop) infl_drop = 1;
      step();
   endtask

   task automatic wait_done();
      for (int i = 0; i < 600 && !(head == tail && !inflight && !fe_valid); i++) step();
      repeat (40) step();
      nchk++;
      if (head != tail) begin
         nerr++;
         $display("FAIL %s: %0d requests issued, expected %0d", cur_tag, head, tail);
      end
   endtask

   task automatic run(int addr, bit vec, int vl, int m, string tag);
      cur_tag = tag;
      issue(addr, vec, vl, m, 1, 0);
      wait_done();
   endtask

   initial begin
      #(8 * 150000);
      nerr++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      nchk++;
      if (mem_req || fill_valid) begin
         nerr++;
         $display("FAIL R11: req=%0b fill=%0b in reset, expected 0 0", mem_req, fill_valid);
      end
      rst_n = 1'b1;
      step();

      // R2 scalar: 100 then 101..103
      run('h100, 0, 0, 0, "R2");
      // R4 resident skip: 205 held
      res['h205] = 1;
      run('h204, 0, 0, 0, "R4");
      // R3 vector 8x16 elements -> 32 lines
      run('h300, 1, 16, 7, "R3");
      // R3 default 1x, VL 5 -> 2 lines
      run('h340, 1, 5, 0, "R3");
      // R3 VL 0 -> none
      run('h380, 1, 0, 3, "R3");
      // R5 page ends
      run('h13E, 0, 0, 0, "R5");
      run('h17F, 0, 0, 0, "R5");
      run('h3F0, 1, 16, 7, "R5");

      // R6 and R9: stall prefetch, check hold, then cancel
      cur_tag = "R6";
      issue('h500, 0, 0, 0, 1, 0);
      for (int i = 0; i < 50 && head < 1; i++) step();
      force_busy = 1;
      repeat (8) step();
      for (int i = 0; i < 3; i++) begin
         step();
         nchk++;
         if (!mem_req || !mem_req_pf || mem_req_addr != 16'h501) begin
            nerr++;
            $display("FAIL R9: req %0b pf %0b addr %0h, expected 1 1 501", mem_req, mem_req_pf, mem_req_addr);
         end
      end
      issue('h600, 0, 0, 0, 1, 0);
      force_busy = 0;
      wait_done();

      // R7: cancel with a prefetch in flight
      cur_tag = "R7";
      fixed_lat = 4;
      issue('h700, 0, 0, 0, 1, 0);
      for (int i = 0; i < 80 && head < 2; i++) step();
      issue('h800, 0, 0, 0, 1, 1);
      wait_done();

      // R8: miss during demand fetch is ignored
      cur_tag = "R8";
      issue('h900, 0, 0, 0, 1, 0);
      for (int i = 0; i < 50 && head < 1; i++) step();
      issue('hA00, 0, 0, 0, 0, 0);
      wait_done();
      fixed_lat = 0;

      // random mix
      for (int s = 0; s < 80; s++) begin
         int a;
         a = int'($urandom % 4000);
         for (int j = 0; j <= 40; j++) res[a + j] = ($urandom % 4 == 0);
         res[a] = 0;
         run(a, 1'($urandom % 2), int'($urandom % 17), int'($urandom % 8), "R2/R3/R4/R5");
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end
endmodule